// File: doc/BRIEF.md
# USB Suspend Indicator Controller

This block follows the power-management condition of a USB device and drives two suspend indicator pins of opposite polarity. External circuitry uses these pins to power down or hold off while the device is not in normal operation. One pin is high while the indication is active. The other pin is low during the same period.

The block takes five event inputs: a device reset (`rst_n`), a pulse that reports suspend signalling seen on the bus, a resume pulse (detected or generated locally), a bus-reset-detected pulse and a configuration-complete pulse. It keeps three internal conditions:
- **unconfigured**: the condition out of any reset, until configuration is reported.
- **active**: the device is configured and running.
- **suspended**: entered only from active.

The indication is asserted in the unconfigured and suspended conditions. A bus reset always forces the block back to unconfigured, because the host must configure the device again. A resume from suspended returns the block to active. When several pulses arrive in the same cycle, one fixed priority decides the outcome.

Top module: `susp_ind_ctrl`

## Requirements
- R1: `susp_hi` and `susp_lo_n` are always complements. The suspended indication is `susp_hi`=1 with `susp_lo_n`=0. The running indication is `susp_hi`=0 with `susp_lo_n`=1.
- R2: While `rst_n` is low, and after it is released, the outputs show the suspended indication until a configuration-complete pulse is accepted.
- R3: A `cfg_done` pulse in the unconfigured condition changes the outputs to the running indication at the first clock edge after the pulse.
- R4: A `sleep_det` pulse while active changes the outputs to the suspended indication at the next clock edge.
- R5: A `resume_evt` pulse while suspended returns the outputs to the running indication at the next clock edge.
- R6: A `busrst_det` pulse in any condition moves the block to unconfigured, with the suspended indication. A later resume does not clear that indication; only `cfg_done` does.
- R7: When pulses coincide, only the highest-priority one acts. The order from highest to lowest is `busrst_det`, `resume_evt`, `sleep_det`, `cfg_done`.
- R8: Three pulses have no effect and leave the outputs unchanged:
  - `resume_evt` or `sleep_det` while unconfigured;
  - `cfg_done` while suspended.
- R9: Driving `rst_n` low in any condition forces the suspended indication at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Device reset, active low, asynchronous assertion |
| sleep_det | input | 1 | One-cycle pulse: suspend signalling seen on the bus |
| resume_evt | input | 1 | One-cycle pulse: resume detected or generated |
| busrst_det | input | 1 | One-cycle pulse: USB bus reset detected |
| cfg_done | input | 1 | One-cycle pulse: configuration finished |
| susp_hi | output | 1 | Suspend indicator, high while suspended |
| susp_lo_n | output | 1 | Suspend indicator, low while suspended |

## Verification
The hardest situations to reach are those in which the block's history matters more than the current pulse. One is a resume that arrives after a bus reset has moved the block out of suspended; the indication must stay asserted in that case. The other is a set of coincident pulses in each of the three conditions. The vector table walks the block through unconfigured, active and suspended in a fixed order, so each coincident-pulse vector lands in a known condition. A directed test then pulls `rst_n` low while the block is active and samples the pins between clock edges.

// File: rtl/susp_pkg.sv
package susp_pkg;
  typedef enum logic [1:0] {
    ST_UNCONF = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_SUSP   = 2'd2
  } susp_state_e;

  // event indices, lowest index wins
  localparam int EV_BUSRST = 0;
  localparam int EV_RESUME = 1;
  localparam int EV_SLEEP  = 2;
  localparam int EV_CFG    = 3;
  localparam int EV_COUNT  = 4;
endpackage

// File: rtl/susp_rst_sync.sv
module susp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/susp_evt_arb.sv
module susp_evt_arb #(
  parameter int N_EVT = 4
) (
  input  logic [N_EVT-1:0] evt,
  output logic [N_EVT-1:0] grant
);
  logic [N_EVT:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N_EVT; i++) begin : g_prio
    assign grant[i]     = evt[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | evt[i];
  end

  // R7: at most one winner, and the top-priority request always wins
  always_comb begin
    assert_single_grant_R7: assert ($onehot0(grant))
      else $error("more than one event granted");
    assert_top_wins_R7: assert (!evt[0] || grant[0])
      else $error("top-priority event not granted");
  end
endmodule

// File: rtl/susp_state_fsm.sv
module susp_state_fsm
  import susp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [EV_COUNT-1:0] grant,
  output susp_state_e         state_q,
  output susp_state_e         state_d
);
  logic state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_UNCONF: begin
        if (grant[EV_CFG]) state_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (grant[EV_BUSRST])     state_d = ST_UNCONF;
        else if (grant[EV_SLEEP]) state_d = ST_SUSP;
      end
      ST_SUSP: begin
        if (grant[EV_BUSRST])      state_d = ST_UNCONF;
        else if (grant[EV_RESUME]) state_d = ST_ACTIVE;
      end
      default: state_d = ST_UNCONF;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_UNCONF;
    else if (state_en) state_q <= state_d;
  end

  assert_cfg_activates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UNCONF && grant[EV_CFG]) |=> state_q == ST_ACTIVE)
    else $error("cfg_done did not activate");

  assert_sleep_enters_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && grant[EV_SLEEP]) |=> state_q == ST_SUSP)
    else $error("suspend not entered");

  assert_resume_wakes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSP && grant[EV_RESUME]) |=> state_q == ST_ACTIVE)
    else $error("resume did not wake");

  assert_busrst_unconf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant[EV_BUSRST] |=> state_q == ST_UNCONF)
    else $error("bus reset did not unconfigure");

  assert_cfg_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSP && grant[EV_CFG]) |=> state_q == ST_SUSP)
    else $error("cfg_done acted while suspended");

  assert_legal_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 2'd3)
    else $error("illegal state");
endmodule

// File: rtl/susp_pin_drv.sv
module susp_pin_drv
  import susp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  susp_state_e state_d,
  input  susp_state_e state_q,
  output logic        susp_hi,
  output logic        susp_lo_n
);
  logic ind_d;
  logic hi_en;
  logic lo_en;

  assign ind_d = (state_d != ST_ACTIVE);
  assign hi_en = (ind_d != susp_hi);
  assign lo_en = (ind_d == susp_lo_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     susp_hi <= 1'b1;
    else if (hi_en) susp_hi <= ind_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     susp_lo_n <= 1'b0;
    else if (lo_en) susp_lo_n <= ~ind_d;
  end

  assert_pins_complement_R1: assert property (@(posedge clk) disable iff (!rst_n)
    susp_hi != susp_lo_n)
    else $error("indicator pins not complementary");

  assert_pins_track_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    susp_hi == (state_q != ST_ACTIVE))
    else $error("indicator disagrees with state");
endmodule

// File: rtl/susp_ind_ctrl.sv
module susp_ind_ctrl
  import susp_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_det,
  input  logic resume_evt,
  input  logic busrst_det,
  input  logic cfg_done,
  output logic susp_hi,
  output logic susp_lo_n
);
  logic                rst_int_n;
  logic [EV_COUNT-1:0] evt;
  logic [EV_COUNT-1:0] grant;
  susp_state_e         state_q;
  susp_state_e         state_d;

  always_comb begin
    evt            = '0;
    evt[EV_BUSRST] = busrst_det;
    evt[EV_RESUME] = resume_evt;
    evt[EV_SLEEP]  = sleep_det;
    evt[EV_CFG]    = cfg_done;
  end

  susp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  susp_evt_arb #(.N_EVT(EV_COUNT)) u_arb (
    .evt   (evt),
    .grant (grant)
  );

  susp_state_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .grant   (grant),
    .state_q (state_q),
    .state_d (state_d)
  );

  susp_pin_drv u_pins (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .state_d   (state_d),
    .state_q   (state_q),
    .susp_hi   (susp_hi),
    .susp_lo_n (susp_lo_n)
  );
endmodule

// File: tb/susp_ind_ctrl_test.sv
module susp_ind_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_det = 1'b0;
  logic resume_evt = 1'b0;
  logic busrst_det = 1'b0;
  logic cfg_done = 1'b0;
  logic susp_hi;
  logic susp_lo_n;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  susp_ind_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_det  (sleep_det),
    .resume_evt (resume_evt),
    .busrst_det (busrst_det),
    .cfg_done   (cfg_done),
    .susp_hi    (susp_hi),
    .susp_lo_n  (susp_lo_n)
  );

  // {req[7:0], busrst, resume, sleep, cfg, expected susp_hi}
  localparam int NV = 18;
  localparam logic [12:0] VEC [NV] = '{
    {8'd2, 4'b0000, 1'b1},  // idle, still unconfigured
    {8'd8, 4'b0100, 1'b1},  // resume while unconfigured
    {8'd8, 4'b0010, 1'b1},  // sleep while unconfigured
    {8'd3, 4'b0001, 1'b0},  // configure
    {8'd3, 4'b0000, 1'b0},
    {8'd4, 4'b0010, 1'b1},  // suspend
    {8'd8, 4'b0001, 1'b1},  // cfg while suspended
    {8'd5, 4'b0100, 1'b0},  // resume
    {8'd7, 4'b0110, 1'b0},  // resume beats sleep
    {8'd4, 4'b0010, 1'b1},
    {8'd7, 4'b1100, 1'b1},  // bus reset beats resume
    {8'd6, 4'b0100, 1'b1},  // resume after bus reset: stays
    {8'd7, 4'b1001, 1'b1},  // bus reset beats cfg
    {8'd3, 4'b0001, 1'b0},
    {8'd6, 4'b1000, 1'b1},  // bus reset while active
    {8'd3, 4'b0001, 1'b0},
    {8'd7, 4'b0011, 1'b1},  // sleep beats cfg
    {8'd7, 4'b0111, 1'b0}   // resume beats sleep and cfg
  };

  task automatic check(input int req, input logic exp_hi);
    checks++;
    if (susp_hi !== exp_hi || susp_lo_n !== ~exp_hi) begin
      errors++;
      $display("FAIL R%0d: susp_hi=%b susp_lo_n=%b expected %b/%b",
               req, susp_hi, susp_lo_n, exp_hi, ~exp_hi);
    end
  endtask

  task automatic step(input logic [3:0] ev, input int req, input logic exp_hi);
    @(negedge clk);
    {busrst_det, resume_evt, sleep_det, cfg_done} = ev;
    @(negedge clk);
    {busrst_det, resume_evt, sleep_det, cfg_done} = 4'b0000;
    check(req, exp_hi);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(9, 1'b1);                      // R9 / R2: during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(2, 1'b1);                      // R2 after release
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4:1], int'(VEC[i][12:5]), VEC[i][0]);
      check(1, VEC[i][0]);               // R1 complement tracked
    end
    // R9: async reset while active, sampled between edges
    step(4'b0000, 5, 1'b0);
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 check(9, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(2, 1'b1);                      // R2: held until configured
    step(4'b0100, 8, 1'b1);              // R8: resume in unconfigured
    step(4'b0001, 3, 1'b0);              // R3
    step(4'b0010, 4, 1'b1);              // R4
    step(4'b1000, 6, 1'b1);              // R6 from suspended
    step(4'b0100, 6, 1'b1);              // R6: resume cannot clear
    step(4'b0001, 3, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule